// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal sync, vertical sync and data-enable strobes for a parallel RGB panel. It also brings out the current pixel and line positions. Each frame is made of lines, and each line runs through four phases in a fixed order: a sync pulse, a back porch, the visible pixels, then a front porch. Frames are built the same way from lines. Every phase length and both visible dimensions are programmed as the wanted count minus one. The block runs on its own clock. The pixel rate is set by a clock-enable input, and every counter advances only on cycles where that enable is high.

Software reaches the block through a single-cycle register bus: a write strobe, an address, write data, and read data that follows the address combinationally. Timing writes land in working copies. Setting the trigger bit marks an update as pending. The working set is then copied into the live set when the next frame starts, and the pending flag clears. Output begins only after an unlock key has been written and both run bits are set. When software drops the run bits, the frame in progress finishes first. Each output, including a forwarded pixel strobe, has its own polarity-inversion bit, and an inversion change takes effect at once.

Top module: `lcd_timing_gen`

## Requirements
- R1: After reset the generator is idle. The sync, data-enable and position outputs are 0, the pending flag is 0, and the live timing set is all zero, so the first frame after start uses one-count phases (4 pixels by 4 lines).
- R2: Until 0x0002FF47 is written to the key register (address 6), the generator stays idle whatever the run bits hold. Any other value written there leaves it locked.
- R3: Once the block is unlocked and both run bits are set, the generator starts at position (0,0). Sync is visible on the second cycle after the write that completed the condition.
- R4: The run condition needs both run bits: bit 0 (immediate) and bit 1 (end-of-frame) of control register 0 (address 0). With either bit alone the generator stays idle.
- R5: A line consists of the hsync pulse (SYNC+1 pixels from pixel 0), then the back porch (BP+1), the visible pixels (W+1), then the front porch (FP+1). The pixel position counts from 0 to the line total minus 1. The horizontal register (address 3) holds sync in bits 7:0, back porch in bits 15:8 and front porch in bits 23:16.
- R6: Frames are built from lines in the same order. Vsync is high during the first VSYNC+1 lines, and the line position counts lines within the frame. The vertical register is at address 2 and uses the horizontal field layout.
- R7: Data enable is high only at visible pixels of visible lines.
- R8: Writes to the timing or size registers do not change the running timing while no update is pending. Setting bit 14 of control register 0 marks an update pending. The pending flag reads back in bit 14 of control register 0 and in bit 25 of the status register (address 5).
- R9: A pending update is copied into the live set on the edge that starts the next frame, where position (0,0) begins. The pending flag clears on that same edge.
- R10: If a trigger write falls on the same edge as an update, the update takes the working values as they stood before that edge, and the flag stays pending for the next frame.
- R11: When the run bits are cleared in mid-frame, the frame runs to its last pixel and then the generator goes idle. The line position, which reads back in bits 29:16 of control register 1 (address 1), then stays 0.
- R12: Bits 0, 1, 2 and 3 of control register 1 invert the pixel strobe output (which otherwise copies the clock enable), hsync, vsync and data enable respectively. This applies at once, including while idle.
- R13: While the clock enable is low, the pixel and line positions hold their values.
- R14: The size register (address 4) holds the visible line count minus one in the field starting at bit 12 and the visible pixel count minus one in the field starting at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_ce | input | 1 | Pixel-rate clock enable |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Register read data for bus_addr |
| pclk_o | output | 1 | Pixel strobe with polarity applied |
| hsync_o | output | 1 | Horizontal sync with polarity applied |
| vsync_o | output | 1 | Vertical sync with polarity applied |
| de_o | output | 1 | Data enable with polarity applied |
| pix_x | output | CNT_W+2 | Pixel position within the line |
| line_y | output | CNT_W+2 | Line position within the frame |

## Verification
The coincidence that matters is a trigger write landing on the same edge that applies a pending update at a frame boundary. The bench first triggers in mid-frame with a changed horizontal setting. It then waits for the last pixel of the frame and issues a second trigger on exactly the edge that wraps to (0,0). It judges the result in two steps: the next frame must follow the changed line length while the flag still reads pending, and the frame after that must show the flag cleared. A second overlap, a run-bit clear that arrives in mid-frame and meets the end-of-frame edge, is judged by the generator reaching the last line before it falls idle.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;
   localparam int ADDR_W = 3;
   localparam logic [ADDR_W-1:0] A_CTRL0 = 3'd0;
   localparam logic [ADDR_W-1:0] A_CTRL1 = 3'd1;
   localparam logic [ADDR_W-1:0] A_VTIME = 3'd2;
   localparam logic [ADDR_W-1:0] A_HTIME = 3'd3;
   localparam logic [ADDR_W-1:0] A_SIZE  = 3'd4;
   localparam logic [ADDR_W-1:0] A_STAT  = 3'd5;
   localparam logic [ADDR_W-1:0] A_KEY   = 3'd6;

   localparam logic [31:0] UNLOCK_KEY = 32'h0002_FF47;

   localparam int B_RUN_NOW   = 0;
   localparam int B_RUN_EOF   = 1;
   localparam int B_TRIG      = 14;
   localparam int B_PEND      = 25;
   localparam int B_LINE_LSB  = 16;
   localparam int B_SIZE_LINE = 12;

   typedef struct packed {
      logic de;
      logic vs;
      logic hs;
      logic pclk;
   } inv_t;
endpackage

// File: rtl/lcd_tg_axis.sv
module lcd_tg_axis #(
   parameter int CNT_W   = 12,
   parameter int PORCH_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 step,
   input  logic [PORCH_W-1:0]   sync_m1,
   input  logic [PORCH_W-1:0]   bp_m1,
   input  logic [PORCH_W-1:0]   fp_m1,
   input  logic [CNT_W-1:0]     act_m1,
   output logic [CNT_W+1:0]     pos,
   output logic                 at_end,
   output logic                 in_sync,
   output logic                 in_act
);
   localparam int POS_W = CNT_W + 2;

   logic [POS_W-1:0] sync_len, act_beg, act_fin, last_pos;

   always_comb begin
      sync_len = POS_W'(sync_m1) + POS_W'(1);
      act_beg  = sync_len + POS_W'(bp_m1) + POS_W'(1);
      act_fin  = act_beg + POS_W'(act_m1) + POS_W'(1);
      last_pos = act_fin + POS_W'(fp_m1);
   end

   assign at_end  = (pos == last_pos);
   assign in_sync = (pos < sync_len);
   assign in_act  = (pos >= act_beg) && (pos < act_fin);

   always_ff @(posedge clk) begin
      if (!rst_n)
         pos <= '0;
      else if (step)
         pos <= at_end ? '0 : pos + POS_W'(1);
   end
endmodule

// File: rtl/lcd_tg_regs.sv
module lcd_tg_regs
   import lcd_tg_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int CNT_W   = 12,
   parameter int PORCH_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [ADDR_W-1:0]     addr,
   input  logic [DATA_W-1:0]     wdata,
   output logic [DATA_W-1:0]     rdata,
   input  logic [CNT_W+1:0]      line_cnt,
   input  logic                  apply,
   output logic                  run_req,
   output logic                  unlocked,
   output logic                  pending,
   output inv_t                  inv,
   output logic [PORCH_W-1:0]    h_sync, h_bp, h_fp,
   output logic [PORCH_W-1:0]    v_sync, v_bp, v_fp,
   output logic [CNT_W-1:0]      h_act, v_act
);
   localparam int POS_W = CNT_W + 2;
   localparam int TW    = 3 * PORCH_W;
   localparam logic [DATA_W-1:0] KEY = DATA_W'(UNLOCK_KEY);

   logic             run_now, run_eof;
   logic [TW-1:0]    work_h, work_v, live_h, live_v;
   logic [CNT_W-1:0] work_w, work_l, live_w, live_l;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_now  <= 1'b0;
         run_eof  <= 1'b0;
         unlocked <= 1'b0;
         pending  <= 1'b0;
         inv      <= '0;
         work_h   <= '0;
         work_v   <= '0;
         work_w   <= '0;
         work_l   <= '0;
         live_h   <= '0;
         live_v   <= '0;
         live_w   <= '0;
         live_l   <= '0;
      end else begin
         if (apply && pending) begin
            live_h <= work_h;
            live_v <= work_v;
            live_w <= work_w;
            live_l <= work_l;
         end
         if (apply)
            pending <= 1'b0;
         if (wr_en) begin
            case (addr)
               A_CTRL0: begin
                  run_now <= wdata[B_RUN_NOW];
                  run_eof <= wdata[B_RUN_EOF];
                  if (wdata[B_TRIG])
                     pending <= 1'b1;
               end
               A_CTRL1: inv    <= inv_t'(wdata[3:0]);
               A_VTIME: work_v <= wdata[TW-1:0];
               A_HTIME: work_h <= wdata[TW-1:0];
               A_SIZE: begin
                  work_w <= wdata[CNT_W-1:0];
                  work_l <= wdata[B_SIZE_LINE +: CNT_W];
               end
               A_KEY: if (wdata == KEY) unlocked <= 1'b1;
               default: ;
            endcase
         end
      end
   end

   assign run_req = run_now & run_eof;
   assign {h_fp, h_bp, h_sync} = live_h;
   assign {v_fp, v_bp, v_sync} = live_v;
   assign h_act = live_w;
   assign v_act = live_l;

   always_comb begin
      rdata = '0;
      case (addr)
         A_CTRL0: begin
            rdata[B_RUN_NOW] = run_now;
            rdata[B_RUN_EOF] = run_eof;
            rdata[B_TRIG]    = pending;
         end
         A_CTRL1: begin
            rdata[3:0]                = inv;
            rdata[B_LINE_LSB +: POS_W] = line_cnt;
         end
         A_VTIME: rdata[TW-1:0] = work_v;
         A_HTIME: rdata[TW-1:0] = work_h;
         A_SIZE: begin
            rdata[CNT_W-1:0]             = work_w;
            rdata[B_SIZE_LINE +: CNT_W]  = work_l;
         end
         A_STAT: rdata[B_PEND] = pending;
         default: ;
      endcase
   end

   logic unused_wdata;
   assign unused_wdata = ^wdata;
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
   import lcd_tg_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int CNT_W   = 12,
   parameter int PORCH_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pix_ce,
   input  logic               bus_wr,
   input  logic [2:0]         bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic               pclk_o,
   output logic               hsync_o,
   output logic               vsync_o,
   output logic               de_o,
   output logic [CNT_W+1:0]   pix_x,
   output logic [CNT_W+1:0]   line_y
);
   localparam int POS_W = CNT_W + 2;

   generate
      if (CNT_W > B_SIZE_LINE || CNT_W < 2) begin : g_bad_cnt
         $error("CNT_W must lie in 2..12 to fit the size register");
      end
      if (PORCH_W > CNT_W || PORCH_W < 1) begin : g_bad_porch
         $error("PORCH_W must lie in 1..CNT_W");
      end
      if (DATA_W < B_LINE_LSB + POS_W || DATA_W <= B_PEND || DATA_W < 3 * PORCH_W) begin : g_bad_data
         $error("DATA_W too narrow for the register fields");
      end
   endgenerate

   logic               running, unlocked, pending, run_req;
   inv_t               inv;
   logic [PORCH_W-1:0] h_sync, h_bp, h_fp, v_sync, v_bp, v_fp;
   logic [CNT_W-1:0]   h_act, v_act;
   logic               h_end, v_end, h_in_sync, v_in_sync, h_in_act, v_in_act;
   logic               step_h, step_v, frame_end, start, apply;
   logic               hs_raw, vs_raw, de_raw;

   assign step_h    = running & pix_ce;
   assign step_v    = step_h & h_end;
   assign frame_end = step_v & v_end;
   assign start     = ~running & pix_ce & unlocked & run_req;
   assign apply     = start | (frame_end & run_req);

   always_ff @(posedge clk) begin
      if (!rst_n)
         running <= 1'b0;
      else if (start)
         running <= 1'b1;
      else if (frame_end && !run_req)
         running <= 1'b0;
   end

   lcd_tg_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .PORCH_W(PORCH_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
      .wdata(bus_wdata), .rdata(bus_rdata), .line_cnt(line_y), .apply(apply),
      .run_req(run_req), .unlocked(unlocked), .pending(pending), .inv(inv),
      .h_sync(h_sync), .h_bp(h_bp), .h_fp(h_fp),
      .v_sync(v_sync), .v_bp(v_bp), .v_fp(v_fp),
      .h_act(h_act), .v_act(v_act)
   );

   lcd_tg_axis #(.CNT_W(CNT_W), .PORCH_W(PORCH_W)) u_hor (
      .clk(clk), .rst_n(rst_n), .step(step_h),
      .sync_m1(h_sync), .bp_m1(h_bp), .fp_m1(h_fp), .act_m1(h_act),
      .pos(pix_x), .at_end(h_end), .in_sync(h_in_sync), .in_act(h_in_act)
   );

   lcd_tg_axis #(.CNT_W(CNT_W), .PORCH_W(PORCH_W)) u_ver (
      .clk(clk), .rst_n(rst_n), .step(step_v),
      .sync_m1(v_sync), .bp_m1(v_bp), .fp_m1(v_fp), .act_m1(v_act),
      .pos(line_y), .at_end(v_end), .in_sync(v_in_sync), .in_act(v_in_act)
   );

   assign hs_raw = running & h_in_sync;
   assign vs_raw = running & v_in_sync;
   assign de_raw = running & h_in_act & v_in_act;

   assign hsync_o = hs_raw ^ inv.hs;
   assign vsync_o = vs_raw ^ inv.vs;
   assign de_o    = de_raw ^ inv.de;
   assign pclk_o  = pix_ce ^ inv.pclk;
endmodule

// File: rtl/lcd_tg_chk.sv
module lcd_tg_chk #(
   parameter int POS_W = 14
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pix_ce,
   input logic             running,
   input logic             unlocked,
   input logic             pending,
   input logic             apply,
   input logic             frame_end,
   input logic             hs_raw,
   input logic             vs_raw,
   input logic             de_raw,
   input logic [POS_W-1:0] pix_x,
   input logic [POS_W-1:0] line_y
);
   assert_idle_home_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> (pix_x == '0) && (line_y == '0));

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> !hs_raw && !vs_raw && !de_raw);

   assert_locked_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !unlocked |-> !running);

   assert_start_home_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(running) |-> (pix_x == '0) && (line_y == '0));

   assert_de_off_sync_R5: assert property (@(posedge clk) disable iff (!rst_n)
      de_raw |-> !hs_raw && !vs_raw);

   assert_hold_ce_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_ce |=> $stable(pix_x) && $stable(line_y));

   assert_pend_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pending) |-> $past(apply));

   assert_stop_at_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(running) |-> $past(frame_end));
endmodule

bind lcd_timing_gen lcd_tg_chk #(.POS_W(POS_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .running(running),
   .unlocked(unlocked), .pending(pending), .apply(apply),
   .frame_end(frame_end), .hs_raw(hs_raw), .vs_raw(vs_raw), .de_raw(de_raw),
   .pix_x(pix_x), .line_y(line_y)
);

// File: tb/lcd_timing_gen_test.sv
module lcd_timing_gen_test;
   localparam int DW = 32;
   localparam int NV = 4;
   // hs, hbp, hfp, width, vs, vbp, vfp, height (plain counts)
   localparam int VEC [NV][8] = '{
      '{1, 1, 1, 4, 1, 1, 1, 2},
      '{2, 3, 1, 6, 2, 1, 2, 3},
      '{3, 2, 2, 8, 1, 2, 1, 4},
      '{1, 2, 3, 5, 3, 1, 1, 3}
   };
   // changed horizontal set used by the R8/R10 tests
   localparam int XHS = 2, XHB = 1, XHF = 2, XW = 5;

   logic clk = 0, rst_n = 0, pix_ce = 1, bus_wr = 0;
   logic [2:0] bus_addr = 0;
   logic [DW-1:0] bus_wdata = 0;
   logic [DW-1:0] bus_rdata;
   logic pclk_o, hsync_o, vsync_o, de_o;
   logic [13:0] pix_x, line_y;
   int nchk = 0, nfail = 0;
   bit done = 0;

   lcd_timing_gen uut (
      .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pclk_o(pclk_o), .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
      .pix_x(pix_x), .line_y(line_y)
   );

   always #4 clk = ~clk;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 0;
   endtask

   function automatic logic [31:0] tword(input int s, input int b, input int f);
      return {8'd0, 8'(f - 1), 8'(b - 1), 8'(s - 1)};
   endfunction

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      bus_addr = a; #1; d = bus_rdata;
   endtask

   task automatic wait_frame_start();
      int n = 0;
      @(negedge clk); #1;
      while (!(pix_x == 0 && line_y == 0) && n < 5000) begin
         @(negedge clk); #1; n++;
      end
   endtask

   // Scans one frame from position (0,0) at the current time.
   task automatic scan_frame(input int hs, hb, hf, w, vs, vb, vf, h, input string tag);
      int eh = 0, ev = 0, ed = 0;
      int ht = hs + hb + w + hf, vt = vs + vb + h + vf;
      for (int j = 0; j < vt; j++) begin
         for (int i = 0; i < ht; i++) begin
            logic exp_de;
            exp_de = (i >= hs + hb) && (i < hs + hb + w) && (j >= vs + vb) && (j < vs + vb + h);
            if (hsync_o !== (i < hs) || pix_x != 14'(i)) eh++;
            if (vsync_o !== (j < vs) || line_y != 14'(j)) ev++;
            if (de_o !== exp_de) ed++;
            @(negedge clk); #1;
         end
      end
      chk({"R5 line phases ", tag}, eh, 0);
      chk({"R6 frame phases ", tag}, ev, 0);
      chk({"R7 data enable ", tag}, ed, 0);
   endtask

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk); #1;
      // R1 reset state
      chk("R1 hsync", hsync_o, 0);
      chk("R1 vsync/de", {vsync_o, de_o}, 0);
      chk("R1 position", {pix_x, line_y}, 0);
      rd(3'd5, d); chk("R1 pending", d[25], 0);

      // R2 wrong key keeps the block locked
      wr(3'd0, 32'h3);
      wr(3'd6, 32'h0002_FF46);
      repeat (6) @(negedge clk); #1;
      chk("R2 locked idle", {hsync_o, pix_x}, 0);

      // R4 a single run bit is not enough
      wr(3'd0, 32'h1);
      wr(3'd6, 32'h0002_FF47);
      repeat (6) @(negedge clk); #1;
      chk("R4 now-bit only idle", {hsync_o, pix_x}, 0);
      wr(3'd0, 32'h2);
      repeat (6) @(negedge clk); #1;
      chk("R4 eof-bit only idle", {hsync_o, pix_x}, 0);

      // R3 start, with all-zero live timing (R1)
      wr(3'd0, 32'h3); #1;
      chk("R3 not yet running", hsync_o, 0);
      @(negedge clk); #1;
      chk("R3 sync at start", {hsync_o, vsync_o}, 2'b11);
      scan_frame(1, 1, 1, 1, 1, 1, 1, 1, "zero shadows R1");

      // Vector table walk (R8, R9, R14)
      for (int k = 0; k < NV; k++) begin
         wr(3'd3, tword(VEC[k][0], VEC[k][1], VEC[k][2]));
         wr(3'd2, tword(VEC[k][4], VEC[k][5], VEC[k][6]));
         wr(3'd4, ((VEC[k][7] - 1) << 12) | (VEC[k][3] - 1));  // R14 size fields
         wr(3'd0, 32'h3 | (1 << 14));
         rd(3'd0, d); chk("R8 pending in ctrl0 bit14", d[14], 1);
         rd(3'd5, d); chk("R8 pending in status bit25", d[25], 1);
         begin
            int n = 0;
            while (bus_rdata[25] && n < 5000) begin
               @(negedge clk); #1; n++;
            end
         end
         chk("R9 update at frame start", {pix_x, line_y}, 0);
         scan_frame(VEC[k][0], VEC[k][1], VEC[k][2], VEC[k][3],
                    VEC[k][4], VEC[k][5], VEC[k][6], VEC[k][7], "R14 vector");
      end

      // R8 a working write without trigger leaves timing unchanged
      wr(3'd3, tword(XHS, XHB, XHF));
      wr(3'd4, ((VEC[3][7] - 1) << 12) | (XW - 1));
      wait_frame_start();
      scan_frame(VEC[3][0], VEC[3][1], VEC[3][2], VEC[3][3],
                 VEC[3][4], VEC[3][5], VEC[3][6], VEC[3][7], "R8 untriggered");

      // R10 trigger coinciding with the applying edge
      wr(3'd0, 32'h3 | (1 << 14));
      begin
         int n = 0;
         int lx = VEC[3][0] + VEC[3][1] + VEC[3][2] + VEC[3][3] - 1;
         int ly = VEC[3][4] + VEC[3][5] + VEC[3][6] + VEC[3][7] - 1;
         #1;
         while (!(pix_x == 14'(lx) && line_y == 14'(ly)) && n < 5000) begin
            @(negedge clk); #1; n++;
         end
      end
      bus_wr = 1; bus_addr = 3'd0; bus_wdata = 32'h3 | (1 << 14);
      @(negedge clk);
      bus_wr = 0;
      rd(3'd5, d);
      chk("R10 still pending after coincident trigger", d[25], 1);
      chk("R10 new frame begins", {pix_x, line_y}, 0);
      scan_frame(XHS, XHB, XHF, XW, VEC[3][4], VEC[3][5], VEC[3][6], VEC[3][7], "R10 applied");
      rd(3'd5, d);
      chk("R9 pending cleared next frame", d[25], 0);

      // R13 clock enable low freezes positions
      repeat (5) @(negedge clk);
      #1;
      begin
         logic [27:0] held;
         held = {pix_x, line_y};
         pix_ce = 0;
         repeat (10) @(negedge clk);
         #1;
         chk("R13 position held", {pix_x, line_y}, held);
         chk("R12 strobe follows ce", pclk_o, 0);
         pix_ce = 1;
      end

      // R11 graceful stop
      wait_frame_start();
      begin
         int n = 0;
         while (line_y != 1 && n < 5000) begin
            @(negedge clk); #1; n++;
         end
      end
      rd(3'd1, d);
      chk("R11 line field mirrors line", d[29:16], 1);
      wr(3'd0, 32'h0);
      begin
         int n = 0;
         int ly = VEC[3][4] + VEC[3][5] + VEC[3][6] + VEC[3][7] - 1;
         #1;
         while (line_y != 14'(ly) && n < 5000) begin
            @(negedge clk); #1; n++;
         end
         chk("R11 frame completes", line_y, ly);
      end
      wait_frame_start();
      begin
         int bad = 0;
         for (int i = 0; i < 20; i++) begin
            if (pix_x != 0 || line_y != 0 || hsync_o !== 0) bad++;
            @(negedge clk); #1;
         end
         chk("R11 idle after stop", bad, 0);
      end
      rd(3'd1, d);
      chk("R11 line field zero idle", d[29:16], 0);

      // R12 polarity controls
      wr(3'd1, 32'hF); #1;
      chk("R12 all inverted", {pclk_o, hsync_o, vsync_o, de_o}, 4'b0111);
      wr(3'd1, 32'h2); #1;
      chk("R12 hsync only", {pclk_o, hsync_o, vsync_o, de_o}, 4'b1100);
      wr(3'd1, 32'h0); #1;
      chk("R12 normal", {pclk_o, hsync_o, vsync_o, de_o}, 4'b1000);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         nchk++; nfail++;
         $display("FAIL watchdog actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end
endmodule